// File: doc/BRIEF.md
# Predicated Dual-Bank Register File

This block holds two banks of general registers, bank A and bank B, with sixteen 32-bit entries in each. It has several read ports. Each port returns one register, or joins an even/odd pair into a 40-bit or 64-bit operand. A single write port stores a 32-bit result, or splits a 40-bit or 64-bit result across a pair.

Every write carries a predicate field. The field names one of five condition registers, or none. The block tests the named register for zero and can invert the test. From that result it commits the write or drops it. The predicate is judged on the register contents from before the clock edge, so a write that targets its own condition register cannot change its own outcome. Pair requests that break the pairing rules, and predicate codes with no meaning, are rejected and reported.

Top module: `prf_regfile`

## Requirements
- R1: After reset, every register in both banks reads as zero, and commit_o and err_o are low.
- R2: A read in mode 00 returns the register zero-extended to 64 bits. A read in mode 10 returns {odd register, even register} of the pair. The bank bit selects A when 0 and B when 1.
- R3: A read in mode 01 returns {24 zero bits, bits [7:0] of the odd register, the even register}.
- R4: A pair request is legal only when its index is even. Mode 11 is always illegal. An illegal read drives rd_err_o high and rd_data_o to zero in the same cycle.
- R5: A committed mode 00 write replaces exactly the addressed register with wr_data_i[31:0]. The change is visible on the read ports after the clock edge.
- R6: A committed mode 10 write stores wr_data_i[31:0] in the even register and wr_data_i[63:32] in the odd register of the pair.
- R7: A committed mode 01 write stores wr_data_i[31:0] in the even register. The odd register receives wr_data_i[39:32] in bits [7:0] and zeros in bits [31:8].
- R8: Predicate bits [2:0] select the condition: 0 means always, 1 means B0, 2 means B1, 3 means B2, 4 means A1, 5 means A2. Bit 3 inverts the test. A selected register commits the write when it is nonzero (when it is zero if bit 3 is set). With select 0 the write always commits.
- R9: A write with predicate select 6 or 7 does not change any register, and err_o is high for one cycle.
- R10: A write with an illegal pair (odd index in mode 01 or 10, or any index in mode 11) does not change any register, and err_o is high for one cycle.
- R11: The predicate uses the condition register's value from before the edge, even when the same write targets that register.
- R12: commit_o is high in the cycle after a write that updated the registers, and low otherwise. commit_o and err_o are never high together, and neither is high after a cycle with no write.
- R13: The read ports work independently of each other, and each can address any bank, index and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_bank_i | input | NRD | Bank of each read port (0 = A, 1 = B) |
| rd_idx_i | input | NRD x 4 | Register index of each read port |
| rd_mode_i | input | NRD x 2 | Width of each read: 00 single, 01 40-bit, 10 64-bit |
| rd_data_o | output | NRD x 64 | Read result of each port |
| rd_err_o | output | NRD | Illegal pair request on that port |
| wr_en_i | input | 1 | Write request |
| wr_bank_i | input | 1 | Write bank |
| wr_idx_i | input | 4 | Write register index |
| wr_mode_i | input | 2 | Write width, encoded as for reads |
| wr_data_i | input | 64 | Write data |
| pred_i | input | 4 | Predicate: [2:0] select, [3] invert |
| commit_o | output | 1 | Previous write was committed |
| err_o | output | 1 | Previous write was rejected |

## Verification
The hardest case is a write that names its own condition register as the predicate, with that register holding the value that flips the decision. Only then does reading the pre-edge value differ from reading the post-edge value. Directed steps load B0 with a nonzero value, then write it with its own inverted predicate and then with its plain predicate, and check commit_o and the stored value after each step. Random writes put zero on the data bus a quarter of the time, so the five condition registers are often zero. This lets both the plain and the inverted predicate be taken and dropped many times.

// File: rtl/prf_pkg.sv
package prf_pkg;

    typedef enum logic [1:0] {
        WM_SINGLE = 2'b00,
        WM_EXT40  = 2'b01,
        WM_WIDE64 = 2'b10,
        WM_BAD    = 2'b11
    } width_mode_e;

    localparam logic [2:0] PSEL_ALWAYS = 3'd0;
    localparam logic [2:0] PSEL_B0     = 3'd1;
    localparam logic [2:0] PSEL_B1     = 3'd2;
    localparam logic [2:0] PSEL_B2     = 3'd3;
    localparam logic [2:0] PSEL_A1     = 3'd4;
    localparam logic [2:0] PSEL_A2     = 3'd5;

    localparam int unsigned NUM_PSRC = 5;
    localparam int unsigned NUM_BANK = 2;

endpackage

// File: rtl/prf_pair_check.sv
module prf_pair_check
    import prf_pkg::*;
(
    input  logic [1:0] mode_i,
    input  logic       idx_lsb_i,
    output logic       legal_o
);
    always_comb begin
        unique case (width_mode_e'(mode_i))
            WM_SINGLE: legal_o = 1'b1;
            WM_EXT40,
            WM_WIDE64: legal_o = ~idx_lsb_i;
            default:   legal_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/prf_pred_eval.sv
module prf_pred_eval
    import prf_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [3:0]                       pred_i,
    input  logic [NUM_PSRC-1:0][DATA_W-1:0]  src_i,
    output logic                             legal_o,
    output logic                             take_o
);
    logic [2:0] sel;
    logic       inv;
    logic       nz;

    assign sel = pred_i[2:0];
    assign inv = pred_i[3];

    always_comb begin
        legal_o = 1'b1;
        nz      = 1'b1;
        unique case (sel)
            PSEL_ALWAYS: nz = 1'b1;
            PSEL_B0:     nz = |src_i[0];
            PSEL_B1:     nz = |src_i[1];
            PSEL_B2:     nz = |src_i[2];
            PSEL_A1:     nz = |src_i[3];
            PSEL_A2:     nz = |src_i[4];
            default: begin
                legal_o = 1'b0;
                nz      = 1'b0;
            end
        endcase
        if (!legal_o) begin
            take_o = 1'b0;
        end else if (sel == PSEL_ALWAYS) begin
            take_o = 1'b1;
        end else begin
            take_o = nz ^ inv;
        end
    end
endmodule

// File: rtl/prf_read_port.sv
module prf_read_port
    import prf_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NREG   = 16,
    parameter int unsigned EXT_W  = 8,
    localparam int unsigned IDX_W = $clog2(NREG)
) (
    input  logic [NUM_BANK-1:0][NREG-1:0][DATA_W-1:0] regs_i,
    input  logic                                      bank_i,
    input  logic [IDX_W-1:0]                          idx_i,
    input  logic [1:0]                                mode_i,
    output logic [2*DATA_W-1:0]                       data_o,
    output logic                                      err_o
);
    logic             legal;
    logic [IDX_W-1:0] idx_odd;
    logic [DATA_W-1:0] lo_word;
    logic [DATA_W-1:0] hi_word;

    prf_pair_check u_chk (
        .mode_i    (mode_i),
        .idx_lsb_i (idx_i[0]),
        .legal_o   (legal)
    );

    assign idx_odd = {idx_i[IDX_W-1:1], 1'b1};
    assign lo_word = regs_i[bank_i][idx_i];
    assign hi_word = regs_i[bank_i][idx_odd];
    assign err_o   = ~legal;

    always_comb begin
        data_o = '0;
        if (legal) begin
            unique case (width_mode_e'(mode_i))
                WM_SINGLE: data_o = {{DATA_W{1'b0}}, lo_word};
                WM_EXT40:  data_o = {{(DATA_W-EXT_W){1'b0}}, hi_word[EXT_W-1:0], lo_word};
                WM_WIDE64: data_o = {hi_word, lo_word};
                default:   data_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/prf_regfile.sv
module prf_regfile
    import prf_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NREG   = 16,
    parameter int unsigned EXT_W  = 8,
    parameter int unsigned NRD    = 2,
    localparam int unsigned IDX_W = $clog2(NREG)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NRD-1:0]                 rd_bank_i,
    input  logic [NRD-1:0][IDX_W-1:0]      rd_idx_i,
    input  logic [NRD-1:0][1:0]            rd_mode_i,
    output logic [NRD-1:0][2*DATA_W-1:0]   rd_data_o,
    output logic [NRD-1:0]                 rd_err_o,
    input  logic                           wr_en_i,
    input  logic                           wr_bank_i,
    input  logic [IDX_W-1:0]               wr_idx_i,
    input  logic [1:0]                     wr_mode_i,
    input  logic [2*DATA_W-1:0]            wr_data_i,
    input  logic [3:0]                     pred_i,
    output logic                           commit_o,
    output logic                           err_o
);
    localparam logic BANK_A = 1'b0;
    localparam logic BANK_B = 1'b1;

    typedef struct packed {
        logic [NUM_BANK-1:0][NREG-1:0][DATA_W-1:0] regs;
        logic                                      commit;
        logic                                      err;
    } state_t;

    state_t q, d;

    logic                            wr_legal;
    logic                            pred_legal;
    logic                            pred_take;
    logic [NUM_PSRC-1:0][DATA_W-1:0] pred_src;
    logic [IDX_W-1:0]                wr_idx_odd;

    // condition sources, in select order 1..5, taken from the current state
    assign pred_src[0] = q.regs[BANK_B][0];
    assign pred_src[1] = q.regs[BANK_B][1];
    assign pred_src[2] = q.regs[BANK_B][2];
    assign pred_src[3] = q.regs[BANK_A][1];
    assign pred_src[4] = q.regs[BANK_A][2];

    assign wr_idx_odd = {wr_idx_i[IDX_W-1:1], 1'b1};

    prf_pair_check u_wr_pair (
        .mode_i    (wr_mode_i),
        .idx_lsb_i (wr_idx_i[0]),
        .legal_o   (wr_legal)
    );

    prf_pred_eval #(.DATA_W(DATA_W)) u_pred (
        .pred_i  (pred_i),
        .src_i   (pred_src),
        .legal_o (pred_legal),
        .take_o  (pred_take)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        prf_read_port #(
            .DATA_W (DATA_W),
            .NREG   (NREG),
            .EXT_W  (EXT_W)
        ) u_port (
            .regs_i (q.regs),
            .bank_i (rd_bank_i[p]),
            .idx_i  (rd_idx_i[p]),
            .mode_i (rd_mode_i[p]),
            .data_o (rd_data_o[p]),
            .err_o  (rd_err_o[p])
        );
    end

    always_comb begin
        d        = q;
        d.commit = 1'b0;
        d.err    = 1'b0;
        if (wr_en_i) begin
            if (!wr_legal || !pred_legal) begin
                d.err = 1'b1;
            end else if (pred_take) begin
                d.commit = 1'b1;
                unique case (width_mode_e'(wr_mode_i))
                    WM_SINGLE: begin
                        d.regs[wr_bank_i][wr_idx_i] = wr_data_i[DATA_W-1:0];
                    end
                    WM_EXT40: begin
                        d.regs[wr_bank_i][wr_idx_i]   = wr_data_i[DATA_W-1:0];
                        d.regs[wr_bank_i][wr_idx_odd] =
                            {{(DATA_W-EXT_W){1'b0}}, wr_data_i[DATA_W+EXT_W-1:DATA_W]};
                    end
                    WM_WIDE64: begin
                        d.regs[wr_bank_i][wr_idx_i]   = wr_data_i[DATA_W-1:0];
                        d.regs[wr_bank_i][wr_idx_odd] = wr_data_i[2*DATA_W-1:DATA_W];
                    end
                    default: d.commit = 1'b0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign commit_o = q.commit;
    assign err_o    = q.err;

endmodule

// File: rtl/prf_regfile_chk.sv
module prf_regfile_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NRD    = 2,
    parameter int unsigned IDX_W  = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NRD-1:0][1:0]          rd_mode_i,
    input logic [NRD-1:0][2*DATA_W-1:0] rd_data_o,
    input logic [NRD-1:0]               rd_err_o,
    input logic                         wr_en_i,
    input logic [IDX_W-1:0]             wr_idx_i,
    input logic [1:0]                   wr_mode_i,
    input logic [3:0]                   pred_i,
    input logic                         commit_o,
    input logic                         err_o
);
    // R10: odd index or bad mode for a pair write is rejected
    a_r10_bad_pair_err: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && ((wr_mode_i == 2'b11) || (wr_mode_i != 2'b00 && wr_idx_i[0])))
        |=> (err_o && !commit_o));

    // R9: undefined predicate select is rejected
    a_r9_bad_pred_err: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && pred_i[2:1] == 2'b11) |=> (err_o && !commit_o));

    // R8: select 0 always commits a legal write
    a_r8_uncond_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && pred_i[2:0] == 3'd0 && wr_mode_i == 2'b00) |=> commit_o);

    // R12: no pulses after an idle cycle, never both at once
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> (!commit_o && !err_o));

    a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_o && err_o));

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        // R4: reserved mode flags the port and returns zero
        a_r4_rd_bad_mode: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_mode_i[p] == 2'b11) |-> rd_err_o[p]);
        a_r4_rd_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
            rd_err_o[p] |-> (rd_data_o[p] == '0));
    end
endmodule

bind prf_regfile prf_regfile_chk #(
    .DATA_W (DATA_W),
    .NRD    (NRD),
    .IDX_W  (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_mode_i (rd_mode_i),
    .rd_data_o (rd_data_o),
    .rd_err_o  (rd_err_o),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (wr_idx_i),
    .wr_mode_i (wr_mode_i),
    .pred_i    (pred_i),
    .commit_o  (commit_o),
    .err_o     (err_o)
);

// File: tb/sim_prf_regfile.sv
module sim_prf_regfile;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        rd_bank_i = '0;
    logic [1:0][3:0]   rd_idx_i = '0;
    logic [1:0][1:0]   rd_mode_i = '0;
    logic [1:0][63:0]  rd_data_o;
    logic [1:0]        rd_err_o;
    logic              wr_en_i = 1'b0;
    logic              wr_bank_i = 1'b0;
    logic [3:0]        wr_idx_i = '0;
    logic [1:0]        wr_mode_i = '0;
    logic [63:0]       wr_data_i = '0;
    logic [3:0]        pred_i = '0;
    logic              commit_o;
    logic              err_o;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [31:0] mdl [2][16];

    always #10 clk = ~clk;

    prf_regfile u0 (.*);

    function automatic bit pair_ok(logic [1:0] mode, logic [3:0] idx);
        if (mode == 2'b00) return 1'b1;
        if (mode == 2'b11) return 1'b0;
        return ~idx[0];
    endfunction

    function automatic logic [63:0] exp_rd(logic b, logic [3:0] idx, logic [1:0] mode);
        logic [3:0] io;
        io = {idx[3:1], 1'b1};
        if (!pair_ok(mode, idx)) return 64'd0;
        case (mode)
            2'b00:   return {32'd0, mdl[b][idx]};
            2'b01:   return {24'd0, mdl[b][io][7:0], mdl[b][idx]};
            default: return {mdl[b][io], mdl[b][idx]};
        endcase
    endfunction

    // returns {legal, take}
    function automatic logic [1:0] pred_eval(logic [3:0] p);
        logic [31:0] v;
        case (p[2:0])
            3'd0: return 2'b11;
            3'd1: v = mdl[1][0];
            3'd2: v = mdl[1][1];
            3'd3: v = mdl[1][2];
            3'd4: v = mdl[0][1];
            3'd5: v = mdl[0][2];
            default: return 2'b00;
        endcase
        return {1'b1, (v != 0) ^ p[3]};
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(string tag, bit en, bit b, logic [3:0] idx, logic [1:0] mode,
                        logic [63:0] data, logic [3:0] p,
                        bit rb0, logic [3:0] ri0, logic [1:0] rm0,
                        bit rb1, logic [3:0] ri1, logic [1:0] rm1);
        logic [1:0] pe;
        bit ok, exp_c, exp_e;
        string rtag;
        @(negedge clk);
        wr_en_i = en; wr_bank_i = b; wr_idx_i = idx; wr_mode_i = mode;
        wr_data_i = data; pred_i = p;
        rd_bank_i = {rb1, rb0}; rd_idx_i = {ri1, ri0}; rd_mode_i = {rm1, rm0};
        #1;
        rtag = (!pair_ok(rm0, ri0)) ? "R4" : (rm0 == 2'b01) ? "R3" : "R2";
        check(rtag, rd_data_o[0], exp_rd(rb0, ri0, rm0));
        check("R4", {63'd0, rd_err_o[0]}, {63'd0, !pair_ok(rm0, ri0)});
        check("R13", rd_data_o[1], exp_rd(rb1, ri1, rm1));
        pe = pred_eval(p);
        ok = pair_ok(mode, idx);
        exp_e = en && (!ok || !pe[1]);
        exp_c = en && ok && pe[1] && pe[0];
        @(posedge clk);
        #1;
        check({tag, " commit"}, {63'd0, commit_o}, {63'd0, exp_c});
        check({tag, " err"}, {63'd0, err_o}, {63'd0, exp_e});
        if (exp_c) begin
            mdl[b][idx] = data[31:0];
            if (mode == 2'b01) mdl[b][{idx[3:1], 1'b1}] = {24'd0, data[39:32]};
            if (mode == 2'b10) mdl[b][{idx[3:1], 1'b1}] = data[63:32];
        end
    endtask

    task automatic peek(string tag, bit b, logic [3:0] idx, logic [1:0] mode, logic [63:0] exp);
        @(negedge clk);
        wr_en_i = 1'b0;
        rd_bank_i[0] = b; rd_idx_i[0] = idx; rd_mode_i[0] = mode;
        #1;
        check(tag, rd_data_o[0], exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 16; i++) mdl[b][i] = 32'd0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 commit", {63'd0, commit_o}, 64'd0);
        check("R1 err", {63'd0, err_o}, 64'd0);
        @(negedge clk); rst_n = 1'b1;
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 16; i += 2) peek("R1", b[0], i[3:0], 2'b10, 64'd0);

        // directed writes of each width
        step("R5", 1, 0, 4'd7, 2'b00, 64'hAAAA_BBBB_1234_5678, 4'd0, 0, 4'd7, 2'b00, 1, 4'd0, 2'b00);
        peek("R5", 0, 4'd7, 2'b00, 64'h0000_0000_1234_5678);
        peek("R5", 0, 4'd6, 2'b00, 64'd0);
        step("R6", 1, 1, 4'd8, 2'b10, 64'hDEAD_BEEF_CAFE_F00D, 4'd0, 1, 4'd8, 2'b10, 0, 4'd7, 2'b00);
        peek("R6", 1, 4'd8, 2'b10, 64'hDEAD_BEEF_CAFE_F00D);
        step("R7", 1, 0, 4'd4, 2'b01, 64'hFFFF_FFFF_FFFF_FFFF, 4'd0, 0, 4'd4, 2'b01, 0, 4'd4, 2'b10);
        peek("R7", 0, 4'd4, 2'b10, 64'h0000_00FF_FFFF_FFFF);
        peek("R3", 1, 4'd8, 2'b01, 64'h0000_00EF_CAFE_F00D);
        step("R10", 1, 0, 4'd3, 2'b10, 64'h1111_1111_2222_2222, 4'd0, 0, 4'd2, 2'b10, 0, 4'd3, 2'b01);
        peek("R10", 0, 4'd2, 2'b10, 64'd0);
        step("R10", 1, 0, 4'd2, 2'b11, 64'h3, 4'd0, 0, 4'd2, 2'b11, 0, 4'd2, 2'b00);
        step("R9", 1, 0, 4'd9, 2'b00, 64'h55, 4'd6, 0, 4'd9, 2'b00, 1, 4'd0, 2'b00);
        step("R9", 1, 0, 4'd9, 2'b00, 64'h55, 4'd15, 0, 4'd9, 2'b00, 1, 4'd0, 2'b00);
        peek("R9", 0, 4'd9, 2'b00, 64'd0);

        // self-predicated writes on B0
        step("R8", 1, 1, 4'd0, 2'b00, 64'd5, 4'd0, 1, 4'd0, 2'b00, 1, 4'd0, 2'b00);
        step("R11", 1, 1, 4'd0, 2'b00, 64'd0, 4'b1001, 1, 4'd0, 2'b00, 1, 4'd0, 2'b00);
        peek("R11", 1, 4'd0, 2'b00, 64'd5);
        step("R11", 1, 1, 4'd0, 2'b00, 64'd0, 4'b0001, 1, 4'd0, 2'b00, 1, 4'd0, 2'b00);
        peek("R11", 1, 4'd0, 2'b00, 64'd0);
        step("R11", 1, 1, 4'd0, 2'b00, 64'd7, 4'b0001, 1, 4'd0, 2'b00, 1, 4'd0, 2'b00);
        peek("R11", 1, 4'd0, 2'b00, 64'd0);
        step("R12", 0, 0, 4'd0, 2'b00, 64'd9, 4'd0, 0, 4'd0, 2'b00, 1, 4'd1, 2'b10);

        // random traffic
        for (int k = 0; k < 4000; k++) begin
            logic [63:0] dv;
            logic [1:0] pe;
            string tg;
            dv = ($urandom % 4 == 0) ? 64'd0 : {$urandom, $urandom};
            pe = 2'b00;
            tg = "R8";
            step(tg, ($urandom % 8) != 0, $urandom % 2, 4'($urandom), 2'($urandom),
                 dv, 4'($urandom), $urandom % 2, 4'($urandom), 2'($urandom),
                 $urandom % 2, 4'($urandom), 2'($urandom));
        end

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule